// File: doc/BRIEF.md
# Fragment-aware translation lookaside buffer

This block is a small, fully associative translation cache. Each stored page table entry carries a 3-bit fragment code that sets the size of the page it maps: 2^(12+code) bytes. A single slot therefore covers a whole aligned, physically contiguous fragment rather than a single 4 KB page. The entry's permission and system flags apply to every base page inside that fragment.

A client presents a virtual address. One clock later the block reports a hit with a physical address and flags, or a miss. An external walker installs entries through a refill port, and an invalidate pulse empties the cache.

A global fragment enable decides whether lookups honour the stored fragment codes. When the enable is clear, every entry is matched and translated as an exact 4 KB page. The enable is applied at lookup time, so it can be changed without refilling.

Top module: `frag_tlb`

## Requirements
- R1: A lookup presented with `lkup_vld` high produces `resp_vld` high on the next clock and only then; `resp_hit` is never high without `resp_vld`.
- R2: Refill entry layout (40 bits):
  - bit 0 is valid, bit 1 is system, bit 5 is readable, bit 6 is writeable;
  - bits 9:7 are the fragment code;
  - bits 39:12 are the physical page number.
  A hit on a code-0 entry returns `{ppn, va[11:0]}` and copies bits 5, 6 and 1 to `resp_rd`, `resp_wr` and `resp_sys`.
- R3: With `frag_en` high, an entry whose code is f matches every virtual page whose number agrees with the refill page number above its low f bits. The returned address keeps the low 12+f bits of the virtual address and takes the bits above them from the stored page number. Pages outside the aligned fragment miss.
- R4: With `frag_en` low at lookup time, the fragment code is ignored: an entry matches only its own refill page and returns its stored page number unmasked.
- R5: A refill whose valid bit (bit 0) is clear is never stored.
- R6: The cache holds 8 entries filled round-robin from slot 0. The ninth stored refill replaces the first.
- R7: `inval_all` empties every slot in one clock and resets the round-robin pointer to slot 0. A lookup in that cycle misses, and a refill in that cycle is dropped.
- R8: A miss drives `resp_hit`, `resp_pa`, `resp_rd`, `resp_wr` and `resp_sys` to zero.
- R9: A lookup in the same cycle as a refill sees the contents from before the refill.
- R10: When several slots match, the lowest-numbered slot supplies the translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frag_en | input | 1 | Honour fragment codes during lookup |
| lkup_vld | input | 1 | Lookup request |
| lkup_va | input | 32 | Lookup virtual address |
| fill_vld | input | 1 | Refill request |
| fill_va | input | 32 | Any virtual address inside the page being refilled |
| fill_pte | input | 40 | Page table entry being refilled |
| inval_all | input | 1 | Empty the cache |
| resp_vld | output | 1 | Response for the previous cycle's lookup |
| resp_hit | output | 1 | Translation found |
| resp_pa | output | 40 | Physical address |
| resp_rd | output | 1 | Readable permission |
| resp_wr | output | 1 | Writeable permission |
| resp_sys | output | 1 | System-memory flag |

## Verification
The assertions assume that `rst` is held high from time zero until the first lookup, and that `inval_all` is a clean single-cycle pulse. They also assume that no refill is stored in the cycle right after an invalidate, because such a refill would be visible to the next lookup. The stimulus drives every input on the falling edge. Its only refill directly after an invalidate is the one the invalidate itself drops. Overlapping entries are installed only in the test that checks the lowest-slot rule.

// File: rtl/frag_tlb_pkg.sv
package frag_tlb_pkg;

    localparam int PG_SH    = 12;          // base page shift
    localparam int FRAG_W   = 3;           // fragment code width
    localparam int FRAG_LSB = 7;           // fragment code position in entry
    localparam int MASK_W   = 1 << FRAG_W; // widest low-page mask
    localparam int BIT_VLD  = 0;
    localparam int BIT_SYS  = 1;
    localparam int BIT_RD   = 5;
    localparam int BIT_WR   = 6;
    localparam int PPN_LSB  = 12;

    typedef struct packed {
        logic sys;
        logic rd;
        logic wr;
    } perm_t;

    function automatic logic [FRAG_W-1:0] eff_frag(input logic [FRAG_W-1:0] code,
                                                   input logic en);
        return en ? code : '0;
    endfunction

    // low page-number bits that lie inside the fragment
    function automatic logic [MASK_W-1:0] frag_lo_mask(input logic [FRAG_W-1:0] code);
        logic [MASK_W:0] one_hot;
        one_hot = (MASK_W+1)'(1) << code;
        return MASK_W'(one_hot - (MASK_W+1)'(1));
    endfunction

endpackage

// File: rtl/frag_tlb_cam.sv
module frag_tlb_cam
    import frag_tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 28,
    parameter int IDX_W   = 3
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           inval,
    input  logic                           frag_en,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [VPN_W-1:0]               wr_vpn,
    input  logic [PPN_W-1:0]               wr_ppn,
    input  logic [FRAG_W-1:0]              wr_frag,
    input  perm_t                          wr_perm,
    input  logic [VPN_W-1:0]               lk_vpn,
    output logic [ENTRIES-1:0]             hit_vec,
    output logic [ENTRIES-1:0][PPN_W-1:0]  ent_ppn,
    output logic [ENTRIES-1:0][FRAG_W-1:0] ent_frag,
    output perm_t [ENTRIES-1:0]            ent_perm
);

    for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
        logic              vld_q;
        logic [VPN_W-1:0]  tag_q;
        logic [PPN_W-1:0]  ppn_q;
        logic [FRAG_W-1:0] frag_q;
        perm_t             perm_q;
        logic              sel_w;
        logic [VPN_W-1:0]  lo_m;

        assign sel_w = wr_en && (wr_idx == IDX_W'(e));

        always_ff @(posedge clk) begin
            if (rst || inval) begin
                vld_q <= 1'b0;
            end else if (sel_w) begin
                vld_q <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (sel_w && !inval) begin
                tag_q  <= wr_vpn;
                ppn_q  <= wr_ppn;
                frag_q <= wr_frag;
                perm_q <= wr_perm;
            end
        end

        assign lo_m       = VPN_W'(frag_lo_mask(eff_frag(frag_q, frag_en)));
        assign hit_vec[e] = vld_q && (((tag_q ^ lk_vpn) & ~lo_m) == '0);
        assign ent_ppn[e]  = ppn_q;
        assign ent_frag[e] = frag_q;
        assign ent_perm[e] = perm_q;
    end

endmodule

// File: rtl/frag_tlb_alloc.sv
module frag_tlb_alloc #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inval,
    input  logic             adv,
    output logic [IDX_W-1:0] ptr
);

    always_ff @(posedge clk) begin
        if (rst || inval) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= (ptr == IDX_W'(ENTRIES - 1)) ? '0 : ptr + IDX_W'(1);
        end
    end

endmodule

// File: rtl/frag_tlb_resp.sv
module frag_tlb_resp
    import frag_tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 28,
    parameter int IDX_W   = 3
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           req_vld,
    input  logic                           inval,
    input  logic                           frag_en,
    input  logic [VPN_W-1:0]               lk_vpn,
    input  logic [PG_SH-1:0]               lk_off,
    input  logic [ENTRIES-1:0]             hit_vec,
    input  logic [ENTRIES-1:0][PPN_W-1:0]  ent_ppn,
    input  logic [ENTRIES-1:0][FRAG_W-1:0] ent_frag,
    input  perm_t [ENTRIES-1:0]            ent_perm,
    output logic                           resp_vld,
    output logic                           resp_hit,
    output logic [PPN_W+PG_SH-1:0]         resp_pa,
    output perm_t                          resp_perm
);

    logic             any_hit;
    logic [IDX_W-1:0] sel;
    logic [VPN_W-1:0] lo_m;
    logic [PPN_W-1:0] page;

    // lowest matching slot wins: scan downward so it is assigned last
    always_comb begin
        any_hit = 1'b0;
        sel     = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (hit_vec[e]) begin
                any_hit = 1'b1;
                sel     = IDX_W'(e);
            end
        end
    end

    assign lo_m = VPN_W'(frag_lo_mask(eff_frag(ent_frag[sel], frag_en)));
    assign page = (ent_ppn[sel] & ~PPN_W'(lo_m)) | PPN_W'(lk_vpn & lo_m);

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_vld  <= 1'b0;
            resp_hit  <= 1'b0;
            resp_pa   <= '0;
            resp_perm <= '0;
        end else begin
            resp_vld <= req_vld;
            if (req_vld && any_hit && !inval) begin
                resp_hit  <= 1'b1;
                resp_pa   <= {page, lk_off};
                resp_perm <= ent_perm[sel];
            end else begin
                resp_hit  <= 1'b0;
                resp_pa   <= '0;
                resp_perm <= '0;
            end
        end
    end

endmodule

// File: rtl/frag_tlb.sv
module frag_tlb
    import frag_tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VA_W    = 32,
    parameter int PA_W    = 40,
    localparam int VPN_W  = VA_W - PG_SH,
    localparam int PPN_W  = PA_W - PG_SH,
    localparam int PTE_W  = PPN_LSB + PPN_W,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frag_en,
    input  logic             lkup_vld,
    input  logic [VA_W-1:0]  lkup_va,
    input  logic             fill_vld,
    input  logic [VA_W-1:0]  fill_va,
    input  logic [PTE_W-1:0] fill_pte,
    input  logic             inval_all,
    output logic             resp_vld,
    output logic             resp_hit,
    output logic [PA_W-1:0]  resp_pa,
    output logic             resp_rd,
    output logic             resp_wr,
    output logic             resp_sys
);

    logic                           fill_take;
    logic [IDX_W-1:0]               wr_ptr;
    perm_t                          fill_perm;
    perm_t                          out_perm;
    logic [ENTRIES-1:0]             hit_vec;
    logic [ENTRIES-1:0][PPN_W-1:0]  ent_ppn;
    logic [ENTRIES-1:0][FRAG_W-1:0] ent_frag;
    perm_t [ENTRIES-1:0]            ent_perm;

    assign fill_take = fill_vld && fill_pte[BIT_VLD] && !inval_all;
    assign fill_perm = '{sys: fill_pte[BIT_SYS], rd: fill_pte[BIT_RD], wr: fill_pte[BIT_WR]};

    frag_tlb_alloc #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_alloc (
        .clk   (clk),
        .rst   (rst),
        .inval (inval_all),
        .adv   (fill_take),
        .ptr   (wr_ptr)
    );

    frag_tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(IDX_W)) u_cam (
        .clk      (clk),
        .rst      (rst),
        .inval    (inval_all),
        .frag_en  (frag_en),
        .wr_en    (fill_take),
        .wr_idx   (wr_ptr),
        .wr_vpn   (fill_va[VA_W-1:PG_SH]),
        .wr_ppn   (fill_pte[PPN_LSB +: PPN_W]),
        .wr_frag  (fill_pte[FRAG_LSB +: FRAG_W]),
        .wr_perm  (fill_perm),
        .lk_vpn   (lkup_va[VA_W-1:PG_SH]),
        .hit_vec  (hit_vec),
        .ent_ppn  (ent_ppn),
        .ent_frag (ent_frag),
        .ent_perm (ent_perm)
    );

    frag_tlb_resp #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(IDX_W)) u_resp (
        .clk       (clk),
        .rst       (rst),
        .req_vld   (lkup_vld),
        .inval     (inval_all),
        .frag_en   (frag_en),
        .lk_vpn    (lkup_va[VA_W-1:PG_SH]),
        .lk_off    (lkup_va[PG_SH-1:0]),
        .hit_vec   (hit_vec),
        .ent_ppn   (ent_ppn),
        .ent_frag  (ent_frag),
        .ent_perm  (ent_perm),
        .resp_vld  (resp_vld),
        .resp_hit  (resp_hit),
        .resp_pa   (resp_pa),
        .resp_perm (out_perm)
    );

    assign resp_rd  = out_perm.rd;
    assign resp_wr  = out_perm.wr;
    assign resp_sys = out_perm.sys;

endmodule

// File: rtl/frag_tlb_chk.sv
module frag_tlb_chk #(
    parameter int VA_W = 32,
    parameter int PA_W = 40
) (
    input logic            clk,
    input logic            rst,
    input logic            lkup_vld,
    input logic [VA_W-1:0] lkup_va,
    input logic            inval_all,
    input logic            resp_vld,
    input logic            resp_hit,
    input logic [PA_W-1:0] resp_pa,
    input logic            resp_rd,
    input logic            resp_wr,
    input logic            resp_sys
);

    p_resp_follows_req_r1: assert property (@(posedge clk) disable iff (rst)
        lkup_vld |=> resp_vld);

    p_no_spurious_resp_r1: assert property (@(posedge clk) disable iff (rst)
        !lkup_vld |=> !resp_vld);

    p_hit_needs_vld_r1: assert property (@(posedge clk) disable iff (rst)
        resp_hit |-> resp_vld);

    p_offset_kept_r2: assert property (@(posedge clk) disable iff (rst)
        (lkup_vld ##1 resp_hit) |-> (resp_pa[11:0] == $past(lkup_va[11:0])));

    p_miss_zero_r8: assert property (@(posedge clk) disable iff (rst)
        !resp_hit |-> (resp_pa == '0 && !resp_rd && !resp_wr && !resp_sys));

    p_inval_same_cycle_r7: assert property (@(posedge clk) disable iff (rst)
        inval_all |=> !resp_hit);

    p_inval_empties_r7: assert property (@(posedge clk) disable iff (rst)
        (inval_all ##1 lkup_vld) |=> !resp_hit);

endmodule

bind frag_tlb frag_tlb_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .lkup_vld  (lkup_vld),
    .lkup_va   (lkup_va),
    .inval_all (inval_all),
    .resp_vld  (resp_vld),
    .resp_hit  (resp_hit),
    .resp_pa   (resp_pa),
    .resp_rd   (resp_rd),
    .resp_wr   (resp_wr),
    .resp_sys  (resp_sys)
);

// File: tb/frag_tlb_tb_top.sv
module frag_tlb_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frag_en = 1'b0;
    logic        lkup_vld = 1'b0;
    logic [31:0] lkup_va = '0;
    logic        fill_vld = 1'b0;
    logic [31:0] fill_va = '0;
    logic [39:0] fill_pte = '0;
    logic        inval_all = 1'b0;
    logic        resp_vld, resp_hit, resp_rd, resp_wr, resp_sys;
    logic [39:0] resp_pa;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frag_tlb dut_i (
        .clk       (clk),
        .rst       (rst),
        .frag_en   (frag_en),
        .lkup_vld  (lkup_vld),
        .lkup_va   (lkup_va),
        .fill_vld  (fill_vld),
        .fill_va   (fill_va),
        .fill_pte  (fill_pte),
        .inval_all (inval_all),
        .resp_vld  (resp_vld),
        .resp_hit  (resp_hit),
        .resp_pa   (resp_pa),
        .resp_rd   (resp_rd),
        .resp_wr   (resp_wr),
        .resp_sys  (resp_sys)
    );

    function automatic logic [39:0] mk_pte(input logic [27:0] ppn, input logic [2:0] frag,
                                           input logic v, input logic s,
                                           input logic r, input logic w);
        return {ppn, 12'h000} | (40'(frag) << 7) | (40'(w) << 6) | (40'(r) << 5)
               | (40'(s) << 1) | 40'(v);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_fill(input logic [31:0] va, input logic [39:0] pte);
        @(negedge clk);
        fill_vld = 1'b1; fill_va = va; fill_pte = pte;
        @(negedge clk);
        fill_vld = 1'b0;
    endtask

    task automatic do_lookup(input logic [31:0] va);
        @(negedge clk);
        lkup_vld = 1'b1; lkup_va = va;
        @(negedge clk);
        lkup_vld = 1'b0;
    endtask

    task automatic expect_hit(input string req, input logic [31:0] va, input logic [39:0] pa,
                              input logic r, input logic w, input logic s);
        do_lookup(va);
        chk({req, " hit"}, 64'(resp_hit), 64'd1);
        chk({req, " pa"}, 64'(resp_pa), 64'(pa));
        chk({req, " flags"}, 64'({resp_rd, resp_wr, resp_sys}), 64'({r, w, s}));
    endtask

    task automatic expect_miss(input string req, input logic [31:0] va);
        do_lookup(va);
        chk({req, " miss"}, 64'(resp_hit), 64'd0);
    endtask

    task automatic do_inval();
        @(negedge clk);
        inval_all = 1'b1;
        @(negedge clk);
        inval_all = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset vld", 64'(resp_vld), 64'd0);
        chk("R8 reset hit", 64'(resp_hit), 64'd0);
        do_lookup(32'h0000_1000);
        chk("R1 vld after lookup", 64'(resp_vld), 64'd1);
        chk("R8 empty miss pa", 64'({resp_hit, resp_pa, resp_rd, resp_wr, resp_sys}), 64'd0);
        @(negedge clk);
        chk("R1 vld drops", 64'(resp_vld), 64'd0);
    endtask

    task automatic t_basic();
        do_fill(32'h0001_2000, mk_pte(28'h0ABCDE, 3'd0, 1, 0, 1, 0));
        do_fill(32'h0002_0000, mk_pte(28'h0000123, 3'd0, 1, 1, 0, 1));
        expect_hit("R2 a", 32'h0001_2345, 40'h0ABCDE345, 1, 0, 0);
        expect_hit("R2 b", 32'h0002_0010, 40'h0000123010, 0, 1, 1);
        expect_miss("R8 neighbour", 32'h0001_3000);
        chk("R8 miss fields", 64'({resp_pa, resp_rd, resp_wr, resp_sys}), 64'd0);
    endtask

    task automatic t_frag();
        frag_en = 1'b1;
        do_fill(32'h0040_3000, mk_pte(28'h010005A, 3'd4, 1, 0, 1, 1));
        do_fill(32'h0080_0000, mk_pte(28'h0200000, 3'd6, 1, 0, 1, 0));
        expect_hit("R3 f4 top", 32'h0040_F123, 40'h010005F123, 1, 1, 0);
        expect_hit("R3 f4 base", 32'h0040_0004, 40'h0100050004, 1, 1, 0);
        expect_miss("R3 f4 outside", 32'h0041_0000);
        expect_hit("R3 f6", 32'h0083_F456, 40'h020003F456, 1, 0, 0);
        expect_miss("R3 f6 outside", 32'h0084_0000);
    endtask

    task automatic t_frag_off();
        frag_en = 1'b0;
        expect_miss("R4 other page", 32'h0040_F123);
        expect_hit("R4 own page", 32'h0040_3ABC, 40'h010005AABC, 1, 1, 0);
        expect_miss("R4 f6 other", 32'h0083_F456);
        frag_en = 1'b1;
        expect_hit("R4 re-enable", 32'h0040_F123, 40'h010005F123, 1, 1, 0);
    endtask

    task automatic t_inval();
        @(negedge clk);
        inval_all = 1'b1; lkup_vld = 1'b1; lkup_va = 32'h0001_2345;
        fill_vld = 1'b1; fill_va = 32'h0005_0000; fill_pte = mk_pte(28'h55, 3'd0, 1, 0, 1, 1);
        @(negedge clk);
        inval_all = 1'b0; lkup_vld = 1'b0; fill_vld = 1'b0;
        chk("R7 same-cycle lookup", 64'(resp_hit), 64'd0);
        expect_miss("R7 cleared a", 32'h0001_2345);
        expect_miss("R7 cleared frag", 32'h0040_F123);
        expect_miss("R7 fill dropped", 32'h0005_0000);
    endtask

    task automatic t_bad_fill();
        do_fill(32'h0200_0000, mk_pte(28'h0777, 3'd0, 0, 0, 1, 1));
        expect_miss("R5 invalid entry", 32'h0200_0000);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        fill_vld = 1'b1; fill_va = 32'h0300_0000; fill_pte = mk_pte(28'h0333, 3'd0, 1, 0, 1, 0);
        lkup_vld = 1'b1; lkup_va = 32'h0300_0020;
        @(negedge clk);
        fill_vld = 1'b0; lkup_vld = 1'b0;
        chk("R9 old contents", 64'(resp_hit), 64'd0);
        expect_hit("R9 next cycle", 32'h0300_0020, 40'h0000333020, 1, 0, 0);
    endtask

    task automatic t_priority();
        do_inval();
        frag_en = 1'b1;
        do_fill(32'h0050_0000, mk_pte(28'h0300000, 3'd4, 1, 0, 1, 0));
        do_fill(32'h0050_5000, mk_pte(28'h0777777, 3'd0, 1, 0, 0, 1));
        expect_hit("R10 lowest slot", 32'h0050_5010, 40'h0300005010, 1, 0, 0);
        frag_en = 1'b0;
        expect_hit("R10 R4 only exact", 32'h0050_5010, 40'h0777777010, 0, 1, 0);
        frag_en = 1'b1;
    endtask

    task automatic t_round_robin();
        do_inval();
        for (int i = 0; i < 9; i++) begin
            do_fill(32'h0100_0000 + 32'((i + 1) * 32'h1000),
                    mk_pte(28'(32'h100 + i), 3'd0, 1, 0, 1, 0));
        end
        expect_miss("R6 oldest evicted", 32'h0100_1000);
        expect_hit("R6 second kept", 32'h0100_2000, 40'h0000101000, 1, 0, 0);
        expect_hit("R6 ninth stored", 32'h0100_9000, 40'h0000108000, 1, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_frag();
        t_frag_off();
        t_inval();
        t_bad_fill();
        t_same_cycle();
        t_priority();
        t_round_robin();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule